// File: doc/BRIEF.md
# Indexed Control-Register and Overlay-RAM Host Port

This block connects an 8-bit microcontroller bus with asynchronous strobes to the clock domain of a video encoder core. The bus has a chip select, a read/write line, one address line and a data byte. The host writes a pointer byte at address 0 and then reads or writes the selected target at address 1. The pointer keeps its value until it is rewritten, so the host can make repeated data accesses to one target without resending it.

When pointer bit 4 is clear, data accesses go to a small bank of control registers. Each register has a defined reset value and drives a configuration output of the block. When bit 4 is set, data writes go to the character overlay RAM instead. Each write leaves the block as a one-cycle write strobe carrying a row, a column and a byte. A column pointer fills the row from the left and wraps after 25 entries.

The block also watches the active-low vertical sync input. It shows a vertical-blank status bit in one read-only location. It lowers an interrupt line at the start of each sync pulse, and the line stays low until software releases it.

Top module: `hostreg_port`

## Requirements
- R1: After an active-low reset the configuration outputs hold their defaults: ctl_filt=0x79, ctl_osd=0x04, ctl_hue=0x00, ctl_mode=0x00, ctl_dac=0x25, ctl_aux=0x00. irq_n is high and bus_oe is low.
- R2: A write at address 0 loads the pointer, and the pointer keeps its value until the next address-0 write. While chip select is low with read/write high, bus_oe is high. An address-1 read then returns the selected target and an address-0 read returns 0x00. Otherwise bus_oe is low.
- R3: A write at address 1 with pointer bit 4 clear and pointer bits 3:0 equal to 0, 1, 3, 4, 5 or 7 loads the byte into that register. The byte shows on the matching ctl_* output and reads back at address 1.
- R4: Writes to pointer locations 6 and 8..15 (bit 4 clear) change no output. Reads from those locations return 0x00.
- R5: A write at address 1 with pointer bit 4 set produces exactly one ovl_we pulse. The pulse carries ovl_row = pointer bits 3:0 and ovl_data = the byte, and it changes no ctl_* output. Reads with bit 4 set return 0x00.
- R6: Successive overlay writes use columns 0, 1, 2 and so on. After the write to column 24 the next write goes to column 0.
- R7: Any address-0 write returns the column pointer to 0.
- R8: A read of location 2 returns bit 7 = inverse of the synchronised vsync_n, bit 1 = 1, and all other bits 0.
- R9: A falling edge on vsync_n drives irq_n low. irq_n stays low until a write to location 2 with data bit 0 = 1. A write with bit 0 = 0 leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low; a write commits when it rises |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 1 | 0 = pointer, 1 = data |
| bus_din | input | 8 | Data byte from the host |
| bus_dout | output | 8 | Data byte to the host |
| bus_oe | output | 1 | Enable for the external data driver |
| vsync_n | input | 1 | Vertical sync, active low |
| irq_n | output | 1 | Interrupt, active low |
| ctl_filt | output | 8 | Register 0 value |
| ctl_osd | output | 8 | Register 1 value |
| ctl_hue | output | 8 | Register 3 value |
| ctl_mode | output | 8 | Register 4 value |
| ctl_dac | output | 8 | Register 5 value |
| ctl_aux | output | 8 | Register 7 value |
| ovl_we | output | 1 | One-cycle overlay RAM write strobe |
| ovl_row | output | 4 | Overlay row |
| ovl_col | output | 5 | Overlay column, 0..24 |
| ovl_data | output | 8 | Overlay byte |

## Verification
Every bus input passes through two synchroniser flops. A write therefore reaches its register, its overlay strobe or the interrupt release on the third clock edge after chip select rises. Read data and bus_oe are valid two edges after chip select falls. An interrupt falls three edges after vsync_n falls. The bench holds each strobe phase for four clocks and samples on the falling clock edge after that hold. This leaves at least one cycle of margin beyond each result's due cycle. Overlay strobes are logged on every falling edge, so a missing pulse or a duplicated pulse appears as a wrong count.

// File: rtl/hp_pkg.sv
// Package: shared widths and register defaults for the host port.
// Assumes an 8-bit bus and eight directly decoded register slots.
package hp_pkg;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 4;
    localparam int NUM_SLOT = 8;
    localparam int STAT_SEL = 2;

    // Reset value of each register slot.
    function automatic logic [DATA_W-1:0] slot_default(input int i);
        case (i)
            0:       return 8'h79;
            1:       return 8'h04;
            5:       return 8'h25;
            default: return 8'h00;
        endcase
    endfunction

    // Slots that hold writable storage.
    function automatic bit slot_writable(input int i);
        return (i == 0) || (i == 1) || (i == 3) || (i == 4) || (i == 5) || (i == 7);
    endfunction
endpackage

// File: rtl/hp_sync.sv
// Module: multi-bit synchroniser chain for quasi-static bus signals.
// Assumes each bit is held long enough for the chain to settle
// (the host holds its strobes for several clocks).
module hp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the sample one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)     stage[s] <= RST_VAL;
                else if (s == 0) stage[s] <= d;
                else            stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hp_regbank.sv
// Module: control register slots with reset defaults, plus the status slot.
// Assumes wr_en is a single-cycle commit pulse. Reserved slots hold no storage.
module hp_regbank
    import hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vblank,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] slot_q [NUM_SLOT]
);
    logic [DATA_W-1:0] status_word;

    generate
        for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
            if (slot_writable(i)) begin : g_rw
                // Load the slot on a committed write that selects it.
                always_ff @(posedge clk) begin
                    if (!rst_n)                              slot_q[i] <= slot_default(i);
                    else if (wr_en && sel == SEL_W'(i))      slot_q[i] <= wr_data;
                end
            end else begin : g_none
                assign slot_q[i] = '0;
            end
        end
    endgenerate

    // Status byte: blank flag on top, constant one in bit 1.
    assign status_word = {vblank, {(DATA_W-3){1'b0}}, 1'b1, 1'b0};

    // Read decode; slots past the bank read as zero.
    always_comb begin
        if (sel == SEL_W'(STAT_SEL))       rd_data = status_word;
        else if (int'(sel) < NUM_SLOT)     rd_data = slot_q[sel[2:0]];
        else                               rd_data = '0;
    end
endmodule

// File: rtl/hp_ovl_ptr.sv
// Module: overlay write formatter with a wrapping column pointer.
// Assumes adv and clr are never high in the same cycle (different bus cycles).
module hp_ovl_ptr #(
    parameter int ROW_LEN = 25,
    parameter int ROW_W   = 4,
    parameter int DW      = 8,
    localparam int COL_W  = $clog2(ROW_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [ROW_W-1:0] row_in,
    input  logic [DW-1:0]    data_in,
    output logic             we,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic [DW-1:0]    data
);
    logic [COL_W-1:0] col_q;

    // Column pointer: step per write, wrap after the last column, clear on pointer write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                          col_q <= '0;
        else if (adv && col_q == COL_W'(ROW_LEN-1)) col_q <= '0;
        else if (adv)                               col_q <= col_q + 1'b1;
    end

    // Registered write strobe and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we <= 1'b0; row <= '0; col <= '0; data <= '0;
        end else begin
            we <= adv;
            if (adv) begin
                row <= row_in; col <= col_q; data <= data_in;
            end
        end
    end
endmodule

// File: rtl/hp_irq.sv
// Module: vertical-sync interrupt latch.
// Assumes vs_n is already synchronised. A new sync edge wins over a release.
module hp_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_n,
    input  logic release_i,
    output logic irq_n
);
    logic vs_prev;

    // Remember last sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_prev <= 1'b1;
        else        vs_prev <= vs_n;
    end

    // Set on sync start, release on software request.
    always_ff @(posedge clk) begin
        if (!rst_n)               irq_n <= 1'b1;
        else if (vs_prev && !vs_n) irq_n <= 1'b0;
        else if (release_i)       irq_n <= 1'b1;
    end
endmodule

// File: rtl/hostreg_port.sv
// Module: top of the indexed host port. It synchronises the bus, decodes
// pointer and data accesses, and steers them to the register bank or the
// overlay formatter. Assumes the host holds every strobe phase for at least
// SYNC_STAGES+1 clocks.
module hostreg_port
    import hp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ROW_LEN     = 25,
    localparam int COL_W      = $clog2(ROW_LEN),
    localparam int BUS_W      = DATA_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_rnw,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic              vsync_n,
    output logic              irq_n,
    output logic [DATA_W-1:0] ctl_filt,
    output logic [DATA_W-1:0] ctl_osd,
    output logic [DATA_W-1:0] ctl_hue,
    output logic [DATA_W-1:0] ctl_mode,
    output logic [DATA_W-1:0] ctl_dac,
    output logic [DATA_W-1:0] ctl_aux,
    output logic              ovl_we,
    output logic [SEL_W-1:0]  ovl_row,
    output logic [COL_W-1:0]  ovl_col,
    output logic [DATA_W-1:0] ovl_data
);
    logic [BUS_W-1:0]  bus_s;
    logic              s_cs_n, s_rnw, s_addr, s_vs_n, cs_prev;
    logic [DATA_W-1:0] s_din, reg_rd;
    logic [SEL_W:0]    ptr_q;
    logic              commit, idx_wr, reg_wr, ovl_wr, irq_clr;
    logic [DATA_W-1:0] slot_q [NUM_SLOT];

    hp_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({3'b111, {DATA_W{1'b0}}}))
        u_bus_sync (.clk(clk), .rst_n(rst_n),
                    .d({bus_cs_n, bus_rnw, bus_addr, bus_din}), .q(bus_s));
    hp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1))
        u_vs_sync (.clk(clk), .rst_n(rst_n), .d(vsync_n), .q(s_vs_n));

    assign {s_cs_n, s_rnw, s_addr, s_din} = bus_s;

    // Previous chip-select level for rising-edge commit.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b1;
        else        cs_prev <= s_cs_n;
    end

    assign commit  = s_cs_n && !cs_prev && !s_rnw;
    assign idx_wr  = commit && !s_addr;
    assign reg_wr  = commit && s_addr && !ptr_q[SEL_W];
    assign ovl_wr  = commit && s_addr && ptr_q[SEL_W];
    assign irq_clr = reg_wr && ptr_q[SEL_W-1:0] == SEL_W'(STAT_SEL) && s_din[0];

    // Pointer register: only bit 4 and the low nibble are decoded.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (idx_wr) ptr_q <= s_din[SEL_W:0];
    end

    hp_regbank u_regs (.clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(ptr_q[SEL_W-1:0]),
                       .wr_data(s_din), .vblank(!s_vs_n), .rd_data(reg_rd), .slot_q(slot_q));

    hp_ovl_ptr #(.ROW_LEN(ROW_LEN), .ROW_W(SEL_W), .DW(DATA_W)) u_ovl (
        .clk(clk), .rst_n(rst_n), .clr(idx_wr), .adv(ovl_wr),
        .row_in(ptr_q[SEL_W-1:0]), .data_in(s_din),
        .we(ovl_we), .row(ovl_row), .col(ovl_col), .data(ovl_data));

    hp_irq u_irq (.clk(clk), .rst_n(rst_n), .vs_n(s_vs_n), .release_i(irq_clr), .irq_n(irq_n));

    // Read path: drive while the synchronised strobe shows a read.
    assign bus_oe   = !s_cs_n && s_rnw;
    assign bus_dout = (s_addr && !ptr_q[SEL_W]) ? reg_rd : '0;

    assign ctl_filt = slot_q[0];
    assign ctl_osd  = slot_q[1];
    assign ctl_hue  = slot_q[3];
    assign ctl_mode = slot_q[4];
    assign ctl_dac  = slot_q[5];
    assign ctl_aux  = slot_q[7];
endmodule

// File: rtl/hostreg_port_chk.sv
// Module: property checker bound to the host port top.
module hostreg_port_chk #(
    parameter int ROW_LEN = 25,
    localparam int COL_W  = $clog2(ROW_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_oe,
    input logic             ovl_we,
    input logic [COL_W-1:0] ovl_col,
    input logic             irq_n,
    input logic             irq_clr,
    input logic [47:0]      ctl_all
);
    AST_OVL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ovl_we |=> !ovl_we); // R5
    AST_OVL_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n) ovl_we |-> $stable(ctl_all)); // R5
    AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) ovl_we |-> (int'(ovl_col) < ROW_LEN)); // R6
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) ovl_we |-> !bus_oe); // R2
    AST_IRQ_RELEASE_BY_SW: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_n) |-> $past(irq_clr)); // R9
endmodule

bind hostreg_port hostreg_port_chk #(.ROW_LEN(ROW_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .ovl_we(ovl_we), .ovl_col(ovl_col),
    .irq_n(irq_n), .irq_clr(irq_clr),
    .ctl_all({ctl_filt, ctl_osd, ctl_hue, ctl_mode, ctl_dac, ctl_aux}));

// File: tb/hostreg_port_bench.sv
module hostreg_port_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, rnw = 1'b1, addr = 1'b0, vs_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, c_filt, c_osd, c_hue, c_mode, c_dac, c_aux, o_data;
    logic oe, irqn, o_we;
    logic [3:0] o_row;
    logic [4:0] o_col;
    int n_run = 0, n_fail = 0, we_count = 0;
    logic [3:0] last_row;
    logic [4:0] last_col;
    logic [7:0] last_data, rd;
    logic [47:0] ctl_snap;

    always #5 clk = ~clk;

    hostreg_port u_hostreg_port (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_rnw(rnw), .bus_addr(addr),
        .bus_din(din), .bus_dout(dout), .bus_oe(oe), .vsync_n(vs_n), .irq_n(irqn),
        .ctl_filt(c_filt), .ctl_osd(c_osd), .ctl_hue(c_hue), .ctl_mode(c_mode),
        .ctl_dac(c_dac), .ctl_aux(c_aux), .ovl_we(o_we), .ovl_row(o_row),
        .ovl_col(o_col), .ovl_data(o_data));

    // Log overlay strobes away from the active edge.
    always @(negedge clk) begin
        if (o_we) begin
            we_count++; last_row = o_row; last_col = o_col; last_data = o_data;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        addr = a; din = d; rnw = 1'b0; cs_n = 1'b0;
        wait_neg(4);
        cs_n = 1'b1;
        wait_neg(4);
        rnw = 1'b1;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d);
        addr = a; rnw = 1'b1; cs_n = 1'b0;
        wait_neg(4);
        d = dout;
        check("R2 oe during read", 64'(oe), 64'd1);
        cs_n = 1'b1;
        wait_neg(4);
    endtask

    // Vector: {op[1:0], data[7:0], expect[7:0]}; op 0 = pointer write, 1 = data write, 2 = data read.
    localparam logic [17:0] VEC [20] = '{
        {2'd0, 8'h01, 8'h00}, {2'd2, 8'h00, 8'h04},   // R1 slot 1 default
        {2'd1, 8'h5A, 8'h00}, {2'd2, 8'h00, 8'h5A},   // R3
        {2'd0, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h79},   // R1 slot 0 default
        {2'd1, 8'h60, 8'h00}, {2'd2, 8'h00, 8'h60},   // R3
        {2'd0, 8'h05, 8'h00}, {2'd2, 8'h00, 8'h25},   // R1 slot 5 default
        {2'd0, 8'h03, 8'h00}, {2'd1, 8'hC3, 8'h00},   // R3 slot 3
        {2'd0, 8'h07, 8'h00}, {2'd1, 8'h11, 8'h00},   // R3 slot 7
        {2'd0, 8'h03, 8'h00}, {2'd2, 8'h00, 8'hC3},   // R2 pointer reselect
        {2'd0, 8'h02, 8'h00}, {2'd2, 8'h00, 8'h02},   // R8 no blank
        {2'd0, 8'h07, 8'h00}, {2'd2, 8'h00, 8'h11}    // R2/R3
    };

    initial begin
        fork
            begin : watchdog
                repeat (150000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=expired expected=finish");
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        join_none

        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);
        // R1 reset state at the ports
        check("R1 ctl", {c_filt, c_osd, c_hue, c_mode, c_dac, c_aux}, 48'h7904_0000_2500);
        check("R1 irq_n", 64'(irqn), 64'd1);
        check("R1 oe idle", 64'(oe), 64'd0);

        foreach (VEC[k]) begin
            if (VEC[k][17:16] == 2'd0)      bus_wr(1'b0, VEC[k][15:8]);
            else if (VEC[k][17:16] == 2'd1) bus_wr(1'b1, VEC[k][15:8]);
            else begin
                bus_rd(1'b1, rd);
                check("R1/R2/R3/R8 table read", 64'(rd), 64'(VEC[k][7:0]));
            end
        end
        check("R3 ctl outputs", {c_filt, c_osd, c_hue, c_mode, c_dac, c_aux}, 48'h605A_C300_2511);
        check("R2 oe after read", 64'(oe), 64'd0);
        bus_rd(1'b0, rd);
        check("R2 address 0 read", 64'(rd), 64'd0);

        // R4 reserved slots
        ctl_snap = {c_filt, c_osd, c_hue, c_mode, c_dac, c_aux};
        bus_wr(1'b0, 8'h06); bus_wr(1'b1, 8'hFF);
        bus_rd(1'b1, rd);
        check("R4 slot 6 reads zero", 64'(rd), 64'd0);
        bus_wr(1'b0, 8'h0A); bus_wr(1'b1, 8'hEE);
        bus_rd(1'b1, rd);
        check("R4 slot 10 reads zero", 64'(rd), 64'd0);
        check("R4 outputs unchanged", {c_filt, c_osd, c_hue, c_mode, c_dac, c_aux}, ctl_snap);

        // R5 overlay burst into row 3
        we_count = 0;
        bus_wr(1'b0, 8'h13);
        bus_wr(1'b1, 8'hA1); bus_wr(1'b1, 8'hA2); bus_wr(1'b1, 8'hA3);
        check("R5 strobe count", 64'(we_count), 64'd3);
        check("R5 row/col/data", {last_row, last_col, last_data}, {4'h3, 5'd2, 8'hA3});
        check("R5 ctl untouched", {c_filt, c_osd, c_hue, c_mode, c_dac, c_aux}, ctl_snap);
        bus_rd(1'b1, rd);
        check("R5 overlay read zero", 64'(rd), 64'd0);

        // R7 pointer rewrite restarts the column
        bus_wr(1'b0, 8'h13);
        bus_wr(1'b1, 8'hB0);
        check("R7 column restart", {last_row, last_col, last_data}, {4'h3, 5'd0, 8'hB0});

        // R6 wrap after 25 writes into row 9
        bus_wr(1'b0, 8'h19);
        we_count = 0;
        for (int j = 0; j < 25; j++) bus_wr(1'b1, 8'(j));
        check("R6 25th column", {last_row, last_col, last_data}, {4'h9, 5'd24, 8'd24});
        bus_wr(1'b1, 8'h77);
        check("R6 wrap to column 0", {last_col, last_data}, {5'd0, 8'h77});
        check("R6 strobe count", 64'(we_count), 64'd26);

        // R8/R9 vertical sync and interrupt
        bus_wr(1'b0, 8'h02);
        vs_n = 1'b0;
        wait_neg(6);
        check("R9 irq on sync start", 64'(irqn), 64'd0);
        bus_rd(1'b1, rd);
        check("R8 blank flag", 64'(rd), 64'h82);
        vs_n = 1'b1;
        wait_neg(6);
        check("R9 irq held after sync", 64'(irqn), 64'd0);
        bus_wr(1'b1, 8'h00);
        check("R9 zero write keeps irq", 64'(irqn), 64'd0);
        bus_wr(1'b1, 8'h01);
        check("R9 release", 64'(irqn), 64'd1);
        bus_rd(1'b1, rd);
        check("R8 flag clear", 64'(rd), 64'h02);

        // R1 reset restores defaults
        rst_n = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);
        check("R1 defaults after reset", {c_filt, c_osd, c_hue, c_mode, c_dac, c_aux}, 48'h7904_0000_2500);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule